// File: doc/BRIEF.md
# Fetch Block Aligner

The fetch block aligner sits between the instruction cache and the decode stage. Each cycle it may accept one naturally aligned fetch block, the program counter that requested it, and an error flag from the cache. It cuts the block into individual instructions. Each 16-bit halfword is examined to decide whether it is a complete compressed instruction or the lower half of a 32-bit one. Instructions are emitted from the requested offset onward as a group of up to `FW` entries. Each entry carries its address, its instruction word and two fault bits.

A 32-bit instruction whose lower half is the final halfword of a block cannot be completed from that block. The aligner keeps that halfword in a carry register. It finishes the instruction when the next accepted request is the block that directly follows. A non-sequential request or a flush throws the carried half away. A cache error marks the first instruction it reaches as faulted, and the rest of that group is suppressed. When only the block holding the upper half of a stitched instruction failed, a separate second-half flag is raised.

Parameters set the address width, the block size (log2 of 4, 8 or 16 bytes) and whether compressed encodings exist. Without compressed encodings, slots are 4 bytes and every parcel starts a 32-bit instruction.

Top module: `fetch_block_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `out_count` is 0. No carried halfword survives reset, so the first block after reset is never stitched to earlier data.
- R2: A halfword whose bits [1:0] are not 2'b11 is a 16-bit instruction and is emitted with bits [31:16] of its word zero. Otherwise the halfword is the low half of a 32-bit word whose bits [31:16] come from the next halfword.
- R3: Emission begins at halfword index `blk_pc[BLK_LOG-1:1]` of the block. Entries appear in increasing address order, starting at entry 0, and each entry carries block base + 2 × its halfword index as its address.
- R4: The group for a block accepted at one clock edge appears with `out_valid` high after that edge and lasts one cycle. `out_count` never exceeds `FW`. It may be 0 when the only parcel left is carried over.
- R5: A 32-bit instruction starting at the final halfword of an error-free block is not emitted with that block. If the next accepted request is exactly the following block base, that instruction is entry 0 of the next group, at its original address, with the new block's halfword 0 as its upper half. Emission then continues at halfword 1.
- R6: A carried halfword is dropped when the next accepted request is not the following block base.
- R7: `flush` clears the carried halfword. A block presented in the same cycle as `flush` produces no output.
- R8: If the block's error flag is set and nothing is carried into it, exactly one entry is emitted, at the start address, with fault code 2'b01 (bit 0 = access fault). This holds even when that parcel is the lower half of a crossing instruction.
- R9: If a stitched instruction's upper-half block has its error flag set, exactly one entry is emitted: the stitched one, with fault code 2'b11 (bit 1 = fault on second half).
- R10: Entries at index `out_count` and above have address, instruction and fault all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop carried halfword, ignore block this cycle |
| blk_valid | input | 1 | A fetch block is presented |
| blk_pc | input | ADDR_W | Requested PC (block base plus start offset) |
| blk_data | input | 8·2^BLK_LOG | Block contents, halfword 0 in the low bits |
| blk_err | input | 1 | Cache reported an error for this block |
| out_valid | output | 1 | Output group valid |
| out_count | output | CNT_W | Number of valid entries |
| out_pc | output | FW×ADDR_W | Per-entry address, entry 0 in the low bits |
| out_instr | output | FW×32 | Per-entry instruction word |
| out_fault | output | FW×2 | Per-entry fault code, bit 0 access, bit 1 second half |

## Verification
The checker assumes that `blk_pc` keeps bit 0 clear and lies within the block whose contents are on `blk_data`. It also assumes a sequential request after a carried half addresses the next block base. The bench only generates even addresses, and it forms each request from a block base plus an in-block offset. Random traffic mostly steps to the next base so that crossings are stitched often. It mixes in jumps, error blocks, idle cycles and flushes. A reference model written from the requirements predicts every group, including the fault code and the address of a stitched entry. Instruction words of faulted entries are not compared.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int FLT_W = 2;
    localparam logic [FLT_W-1:0] FLT_NONE   = 2'b00;
    localparam logic [FLT_W-1:0] FLT_ACCESS = 2'b01;
    localparam logic [FLT_W-1:0] FLT_SECOND = 2'b10;

    // A parcel opens a 32-bit instruction when both low bits are set.
    function automatic logic parcel_is_long(input logic [15:0] parcel);
        return parcel[1:0] == 2'b11;
    endfunction

endpackage

// File: rtl/fa_parcel_decode.sv
module fa_parcel_decode
    import fa_pkg::*;
#(
    parameter int HALVES = 4,
    parameter bit RVC    = 1'b1
) (
    input  logic [HALVES-1:0][15:0] halves,
    output logic [HALVES-1:0]       is_long
);

    for (genvar g = 0; g < HALVES; g++) begin : g_parcel
        if (RVC) begin : g_mixed
            assign is_long[g] = parcel_is_long(halves[g]);
        end else begin : g_wide
            // Without compressed encodings every slot holds a 32-bit word.
            assign is_long[g] = 1'b1;
        end
    end

endmodule

// File: rtl/fa_slot_walker.sv
module fa_slot_walker
    import fa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HALVES = 4,
    parameter int FW     = 4,
    parameter int HIDX_W = 2,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic [HALVES-1:0][15:0]       halves,
    input  logic [HALVES-1:0]             is_long,
    input  logic [ADDR_W-1:0]             base_pc,
    input  logic [HIDX_W-1:0]             start_h,
    input  logic                          blk_err,
    input  logic                          use_carry,
    input  logic [15:0]                   carry_half,
    input  logic [ADDR_W-1:0]             carry_pc,
    output logic [FW-1:0][ADDR_W-1:0]     ent_pc,
    output logic [FW-1:0][31:0]           ent_instr,
    output logic [FW-1:0][FLT_W-1:0]      ent_flt,
    output logic [CNT_W-1:0]              ent_cnt,
    output logic                          nh_vld,
    output logic [15:0]                   nh_half,
    output logic [ADDR_W-1:0]             nh_pc
);

    logic [FLT_W-1:0] blk_flt;
    assign blk_flt = blk_err ? FLT_ACCESS : FLT_NONE;

    always_comb begin
        int   cnt;
        logic stop;
        logic skip;
        cnt       = 0;
        stop      = 1'b0;
        skip      = 1'b0;
        ent_pc    = '0;
        ent_instr = '0;
        ent_flt   = '0;
        nh_vld    = 1'b0;
        nh_half   = '0;
        nh_pc     = '0;

        // Stitched entry: carried low half plus this block's halfword 0.
        if (use_carry) begin
            ent_pc[0]    = carry_pc;
            ent_instr[0] = {halves[0], carry_half};
            ent_flt[0]   = blk_err ? (FLT_ACCESS | FLT_SECOND) : FLT_NONE;
            cnt          = 1;
            skip         = 1'b1;
            stop         = blk_err;
        end

        for (int p = 0; p < HALVES; p++) begin
            if (!stop && p >= int'(start_h)) begin
                if (skip) begin
                    skip = 1'b0;
                end else if (!is_long[p]) begin
                    if (cnt < FW) begin
                        ent_pc[IDX_W'(cnt)]    = base_pc + ADDR_W'(2 * p);
                        ent_instr[IDX_W'(cnt)] = {16'h0000, halves[p]};
                        ent_flt[IDX_W'(cnt)]   = blk_flt;
                    end
                    cnt  = cnt + 1;
                    stop = blk_err;
                end else if (p == HALVES - 1) begin
                    if (blk_err) begin
                        if (cnt < FW) begin
                            ent_pc[IDX_W'(cnt)]    = base_pc + ADDR_W'(2 * p);
                            ent_instr[IDX_W'(cnt)] = {16'h0000, halves[p]};
                            ent_flt[IDX_W'(cnt)]   = FLT_ACCESS;
                        end
                        cnt = cnt + 1;
                    end else begin
                        nh_vld  = 1'b1;
                        nh_half = halves[p];
                        nh_pc   = base_pc + ADDR_W'(2 * p);
                    end
                    stop = 1'b1;
                end else begin
                    if (cnt < FW) begin
                        ent_pc[IDX_W'(cnt)]    = base_pc + ADDR_W'(2 * p);
                        ent_instr[IDX_W'(cnt)] = {halves[(p + 1) % HALVES], halves[p]};
                        ent_flt[IDX_W'(cnt)]   = blk_flt;
                    end
                    cnt  = cnt + 1;
                    skip = 1'b1;
                    stop = blk_err;
                end
            end
        end
        ent_cnt = CNT_W'(cnt);
    end

endmodule

// File: rtl/fetch_block_aligner.sv
module fetch_block_aligner
    import fa_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_LOG = 3,
    parameter bit RVC     = 1'b1,
    localparam int BLK_BYTES = 1 << BLK_LOG,
    localparam int BLK_BITS  = BLK_BYTES * 8,
    localparam int HALVES    = BLK_BYTES / 2,
    localparam int SLOT_LOG  = RVC ? 1 : 2,
    localparam int FW        = BLK_BYTES >> SLOT_LOG,
    localparam int CNT_W     = $clog2(FW + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        blk_valid,
    input  logic [ADDR_W-1:0]           blk_pc,
    input  logic [BLK_BITS-1:0]         blk_data,
    input  logic                        blk_err,
    output logic                        out_valid,
    output logic [CNT_W-1:0]            out_count,
    output logic [FW-1:0][ADDR_W-1:0]   out_pc,
    output logic [FW-1:0][31:0]         out_instr,
    output logic [FW-1:0][FLT_W-1:0]    out_fault
);

    localparam int HIDX_W = BLK_LOG - 1;
    localparam int IDX_W  = (FW > 1) ? $clog2(FW) : 1;

    typedef struct packed {
        logic                       out_valid;
        logic [CNT_W-1:0]           out_cnt;
        logic [FW-1:0][ADDR_W-1:0]  out_pc;
        logic [FW-1:0][31:0]        out_instr;
        logic [FW-1:0][FLT_W-1:0]   out_flt;
        logic                       hold_vld;
        logic [15:0]                hold_half;
        logic [ADDR_W-1:0]          hold_pc;
    } state_t;

    state_t s_d, s_q;

    logic [HALVES-1:0][15:0]     halves;
    logic [HALVES-1:0]           is_long;
    logic [BLK_LOG-1:0]          off_al;
    logic [HIDX_W-1:0]           start_h;
    logic [ADDR_W-1:0]           base_pc;
    logic                        use_carry;
    logic [FW-1:0][ADDR_W-1:0]   w_pc;
    logic [FW-1:0][31:0]         w_instr;
    logic [FW-1:0][FLT_W-1:0]    w_flt;
    logic [CNT_W-1:0]            w_cnt;
    logic                        nh_vld;
    logic [15:0]                 nh_half;
    logic [ADDR_W-1:0]           nh_pc;

    assign halves  = blk_data;
    assign off_al  = RVC ? blk_pc[BLK_LOG-1:0] : (blk_pc[BLK_LOG-1:0] & ~BLK_LOG'(3));
    assign start_h = off_al[BLK_LOG-1:1];
    assign base_pc = {blk_pc[ADDR_W-1:BLK_LOG], {BLK_LOG{1'b0}}};

    // The carried half is only completed by the block right after it.
    assign use_carry = s_q.hold_vld && (s_q.hold_pc + ADDR_W'(2) == blk_pc);

    fa_parcel_decode #(
        .HALVES (HALVES),
        .RVC    (RVC)
    ) i_decode (
        .halves  (halves),
        .is_long (is_long)
    );

    fa_slot_walker #(
        .ADDR_W (ADDR_W),
        .HALVES (HALVES),
        .FW     (FW),
        .HIDX_W (HIDX_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) i_walker (
        .halves     (halves),
        .is_long    (is_long),
        .base_pc    (base_pc),
        .start_h    (start_h),
        .blk_err    (blk_err),
        .use_carry  (use_carry),
        .carry_half (s_q.hold_half),
        .carry_pc   (s_q.hold_pc),
        .ent_pc     (w_pc),
        .ent_instr  (w_instr),
        .ent_flt    (w_flt),
        .ent_cnt    (w_cnt),
        .nh_vld     (nh_vld),
        .nh_half    (nh_half),
        .nh_pc      (nh_pc)
    );

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_cnt   = '0;
        s_d.out_pc    = '0;
        s_d.out_instr = '0;
        s_d.out_flt   = '0;
        if (flush) begin
            s_d.hold_vld  = 1'b0;
            s_d.hold_half = '0;
            s_d.hold_pc   = '0;
        end else if (blk_valid) begin
            s_d.out_valid = 1'b1;
            s_d.out_cnt   = w_cnt;
            s_d.out_pc    = w_pc;
            s_d.out_instr = w_instr;
            s_d.out_flt   = w_flt;
            s_d.hold_vld  = nh_vld;
            s_d.hold_half = nh_half;
            s_d.hold_pc   = nh_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.out_valid;
    assign out_count = s_q.out_cnt;
    assign out_pc    = s_q.out_pc;
    assign out_instr = s_q.out_instr;
    assign out_fault = s_q.out_flt;

endmodule

// File: rtl/fetch_block_aligner_chk.sv
module fetch_block_aligner_chk
    import fa_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_LOG = 3,
    parameter bit RVC     = 1'b1,
    localparam int BLK_BYTES = 1 << BLK_LOG,
    localparam int BLK_BITS  = BLK_BYTES * 8,
    localparam int SLOT_LOG  = RVC ? 1 : 2,
    localparam int FW        = BLK_BYTES >> SLOT_LOG,
    localparam int CNT_W     = $clog2(FW + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        flush,
    input logic                        blk_valid,
    input logic [ADDR_W-1:0]           blk_pc,
    input logic [BLK_BITS-1:0]         blk_data,
    input logic                        blk_err,
    input logic                        out_valid,
    input logic [CNT_W-1:0]            out_count,
    input logic [FW-1:0][ADDR_W-1:0]   out_pc,
    input logic [FW-1:0][31:0]         out_instr,
    input logic [FW-1:0][FLT_W-1:0]    out_fault
);

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CNT_W'(FW))
        else $error("count above fetch width");

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(blk_valid && !flush))
        else $error("group without accepted block");

    p_flush_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !out_valid)
        else $error("group after flush");

    p_fault_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault[0] != FLT_NONE) |-> out_count == CNT_W'(1))
        else $error("faulted group with extra entries");

    p_second_implies_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault[0][1] |-> out_fault[0][0])
        else $error("second-half flag without access flag");

    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_count == '0)
        else $error("count while idle");

    if (FW > 1) begin : g_order
        p_pc_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_count >= CNT_W'(2)) |-> out_pc[1] > out_pc[0])
            else $error("entries out of address order");
    end

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < FW; i++) begin
                if (i >= int'(out_count)) begin
                    p_unused_zero_r10: assert (out_pc[i] == '0 && out_instr[i] == '0 && out_fault[i] == '0)
                        else $error("unused entry %0d not zero", i);
                end
            end
        end
    end

endmodule

bind fetch_block_aligner fetch_block_aligner_chk #(
    .ADDR_W  (ADDR_W),
    .BLK_LOG (BLK_LOG),
    .RVC     (RVC)
) i_chk (.*);

// File: tb/test_fetch_block_aligner.sv
module test_fetch_block_aligner;

    localparam int ADDR_W = 32;
    localparam int FW     = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     flush = 1'b0;
    logic                     blk_valid = 1'b0;
    logic [ADDR_W-1:0]        blk_pc = '0;
    logic [63:0]              blk_data = '0;
    logic                     blk_err = 1'b0;
    logic                     out_valid;
    logic [2:0]               out_count;
    logic [FW-1:0][ADDR_W-1:0] out_pc;
    logic [FW-1:0][31:0]      out_instr;
    logic [FW-1:0][1:0]       out_fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state
    logic        m_hold = 1'b0;
    logic [31:0] m_hold_pc = '0;
    logic [15:0] m_hold_half = '0;
    logic        e_valid;
    int          e_cnt;
    logic [31:0] e_pc  [FW];
    logic [31:0] e_ins [FW];
    logic [1:0]  e_flt [FW];

    always #4 clk = ~clk;

    fetch_block_aligner #(.ADDR_W(ADDR_W), .BLK_LOG(3), .RVC(1'b1)) i_fetch_block_aligner (
        .clk(clk), .rst_n(rst_n), .flush(flush), .blk_valid(blk_valid), .blk_pc(blk_pc),
        .blk_data(blk_data), .blk_err(blk_err), .out_valid(out_valid), .out_count(out_count),
        .out_pc(out_pc), .out_instr(out_instr), .out_fault(out_fault)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] pc, input logic [31:0] ins, input logic [1:0] flt);
        if (e_cnt < FW) begin
            e_pc[e_cnt]  = pc;
            e_ins[e_cnt] = ins;
            e_flt[e_cnt] = flt;
        end
        e_cnt++;
    endtask

    function automatic logic [15:0] hw(input logic [63:0] d, input int i);
        return d[16*i +: 16];
    endfunction

    task automatic model(input logic v, input logic [31:0] pc, input logic [63:0] d,
                         input logic err, input logic fl);
        logic [31:0] base;
        int p;
        bit fin;
        e_cnt = 0;
        for (int i = 0; i < FW; i++) begin
            e_pc[i] = '0; e_ins[i] = '0; e_flt[i] = '0;
        end
        e_valid = v && !fl;
        if (fl) begin
            m_hold = 1'b0;
            return;
        end
        if (!v) return;
        base = pc & ~32'd7;
        p    = int'(pc[2:1]);
        fin  = 1'b0;
        if (m_hold && (m_hold_pc + 32'd2 == pc)) begin
            put(m_hold_pc, {hw(d, 0), m_hold_half}, err ? 2'b11 : 2'b00);
            p   = 1;
            fin = err;
        end
        m_hold = 1'b0;
        while (!fin && p < 4) begin
            logic [15:0] h;
            h = hw(d, p);
            if (h[1:0] != 2'b11) begin
                put(base + 32'(2 * p), {16'h0, h}, err ? 2'b01 : 2'b00);
                p++;
            end else if (p == 3) begin
                if (err) put(base + 32'd6, '0, 2'b01);
                else begin
                    m_hold = 1'b1; m_hold_pc = base + 32'd6; m_hold_half = h;
                end
                fin = 1'b1;
            end else begin
                put(base + 32'(2 * p), {hw(d, p + 1), h}, err ? 2'b01 : 2'b00);
                p += 2;
            end
            if (err) fin = 1'b1;
        end
    endtask

    task automatic step(input logic v, input logic [31:0] pc, input logic [63:0] d,
                        input logic err, input logic fl, input string tag);
        @(negedge clk);
        blk_valid = v; blk_pc = pc; blk_data = d; blk_err = err; flush = fl;
        model(v, pc, d, err, fl);
        @(posedge clk);
        #2;
        check(tag, "valid", 32'(out_valid), 32'(e_valid));
        if (e_valid) begin
            check(tag, "count", 32'(out_count), 32'(e_cnt));
            for (int i = 0; i < FW; i++) begin
                if (i < e_cnt) begin
                    check(tag, "pc", out_pc[i], e_pc[i]);
                    check(tag, "fault", 32'(out_fault[i]), 32'(e_flt[i]));
                    if (e_flt[i] == 2'b00) check(tag, "instr", out_instr[i], e_ins[i]);
                end else begin
                    check("R10", "unused", out_pc[i] | out_instr[i] | 32'(out_fault[i]), 32'h0);
                end
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] nxt;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #2;
        check("R1", "valid in reset", 32'(out_valid), 32'h0);
        check("R1", "count in reset", 32'(out_count), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "valid after reset", 32'(out_valid), 32'h0);

        // R1: block at a base where a stale carry would stitch
        step(1, 32'h0000_0008, {16'h0005, 16'h0004, 16'h0009, 16'h1111}, 0, 0, "R1");
        // R2: mix of 16-bit and 32-bit parcels
        step(1, 32'h0000_0100, {16'h2222, 16'h1113, 16'h0002, 16'hA001}, 0, 0, "R2");
        step(1, 32'h0000_0180, {16'h4444, 16'h3333, 16'h2222, 16'h1113}, 0, 0, "R2");
        // R3: start in the middle of a block
        step(1, 32'h0000_0104, {16'h0F00, 16'h0E00, 16'h0D03, 16'h0C02}, 0, 0, "R3");
        // R5: crossing instruction stitched with the next block
        step(1, 32'h0000_0200, {16'h0003, 16'h0010, 16'h0020, 16'h0030}, 0, 0, "R5");
        step(1, 32'h0000_0208, {16'h0044, 16'h0040, 16'h0050, 16'hBEEF}, 0, 0, "R5");
        // R6: carried half dropped on a jump
        step(1, 32'h0000_0300, {16'h00F3, 16'h0010, 16'h0020, 16'h0030}, 0, 0, "R6");
        step(1, 32'h0000_0400, {16'h0044, 16'h0040, 16'h0050, 16'h0060}, 0, 0, "R6");
        // R7: flush alone, then the would-be sequential block
        step(1, 32'h0000_0500, {16'h00F3, 16'h0010, 16'h0020, 16'h0030}, 0, 0, "R7");
        step(0, 32'h0, 64'h0, 0, 1, "R7");
        step(1, 32'h0000_0508, {16'h0044, 16'h0040, 16'h0050, 16'h0060}, 0, 0, "R7");
        // R7: flush with a block in the same cycle
        step(1, 32'h0000_0600, {16'h0044, 16'h0040, 16'h0050, 16'h0060}, 0, 1, "R7");
        // R8: error block, start mid-block
        step(1, 32'h0000_0702, {16'h0044, 16'h0040, 16'h0050, 16'h0060}, 1, 0, "R8");
        // R8: error block starting on a crossing parcel
        step(1, 32'h0000_0786, {16'h0003, 16'h0040, 16'h0050, 16'h0060}, 1, 0, "R8");
        // R9: second-half fault
        step(1, 32'h0000_0800, {16'h0003, 16'h0010, 16'h0020, 16'h0030}, 0, 0, "R9");
        step(1, 32'h0000_0808, {16'h0044, 16'h0040, 16'h0050, 16'h0060}, 1, 0, "R9");
        // R4: only a carried parcel, count 0; then an idle cycle
        step(1, 32'h0000_0906, {16'h0003, 16'h0040, 16'h0050, 16'h0060}, 0, 0, "R4");
        step(0, 32'h0, 64'h0, 0, 0, "R4");
        step(1, 32'h0000_0908, {16'h0001, 16'h0001, 16'h0001, 16'h7777}, 0, 0, "R5");

        // Random traffic
        nxt = 32'h0000_1000;
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] d;
            logic [31:0] pc;
            int r;
            for (int i = 0; i < 4; i++) begin
                logic [15:0] h;
                h = 16'($urandom);
                if ($urandom_range(0, 1) == 1) h[1:0] = 2'b11;
                d[16*i +: 16] = h;
            end
            r = int'($urandom_range(0, 99));
            if (r < 80) pc = nxt;
            else pc = {16'h0000, 16'($urandom) & 16'hFFFE};
            step($urandom_range(0, 99) < 90, pc, d, $urandom_range(0, 99) < 8,
                 $urandom_range(0, 99) < 4, "R3");
            if (blk_valid) nxt = (pc & ~32'd7) + 32'd8;
        end
        step(0, 32'h0, 64'h0, 0, 0, "R4");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule